// File: doc/BRIEF.md
# Parity-Checked Simple Dual-Port Byte Memory

This block is a single-clock memory of 64 bytes with one port that only writes and one port that only reads. Both ports may be used in the same cycle. Every stored byte carries one even-parity bit, so the array holds 64 words of 9 bits (576 bits). The parity bit is generated as the byte is written, and it is checked again on every read. The read port returns the byte together with a flag that reports a mismatch between the stored parity bit and the byte.

A static parameter selects what the read port returns when a read and a write hit the same address in one cycle. In the old-data variant the read port captures the array word into an output register, so it returns the contents from before the write and holds them until the next read. In the new-data variant the read port registers only the address and looks up the array through it, so the freshly written byte appears at once. The output then keeps following the array at that address. A test input can store the inverted parity bit along with a write, so that the error path can be exercised. The array has no reset. The read output starts at zero with the error flag low.

Top module: `parity_dpram`

## Requirements
- R1: After reset, and until the first read is accepted, rdData is 0 and parityErr is 0, even if writes take place.
- R2: A write takes effect on a rising clock edge only while wrEn is 1. With wrEn at 0, wrAddr and wrData leave the array unchanged.
- R3: A read with rdEn at 1 at a rising edge presents the addressed byte on rdData right after that edge. In old-data mode (RD_MODE = RD_OLD, the default), rdData and parityErr hold while rdEn is 0.
- R4: The stored parity bit is the XOR of the 8 data bits (even parity over the 9-bit word). parityErr is 0 on a read of any byte written with injFlip at 0.
- R5: A write with injFlip at 1 stores the inverted parity bit. The next read of that address returns the written byte with parityErr at 1, and a later normal write clears the condition.
- R6: In old-data mode, a read and a write to the same address in one cycle return the previous contents. The new byte is returned by a read in the following cycle.
- R7: In new-data mode (RD_MODE = RD_NEW), a read and a write to the same address in one cycle return the byte just written, with parityErr at 0.
- R8: A write and a read to different addresses in the same cycle do not disturb each other.
- R9: All 64 addresses hold distinct bytes independently.
- R10: In new-data mode, after a read, a later write to the held read address appears on rdData right after the write edge, without a new read. In old-data mode, rdData keeps the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset of the read output state |
| wrEn | input | 1 | Write enable for the write port |
| wrAddr | input | 6 | Write address |
| wrData | input | 8 | Byte to store |
| injFlip | input | 1 | With wrEn, store the inverted parity bit (error injection) |
| rdEn | input | 1 | Read enable for the read port |
| rdAddr | input | 6 | Read address |
| rdData | output | 8 | Byte returned by the read port |
| parityErr | output | 1 | Stored parity does not match the returned byte |

## Verification
Read results are due one rising edge after the edge that accepts rdEn, and the bench samples them 1 ns after that edge, before the next inputs are applied. A write is visible to a read issued at the following edge, or, in new-data mode, at the write edge itself when the addresses match. The new-data follow-up of R10 is therefore checked right after the write edge, with no read issued. Both modes are instantiated side by side on the same stimulus, and each has its own expected value, so the same-address cases show the one-edge difference directly.

// File: rtl/parity_dpram_pkg.sv
package parity_dpram_pkg;

  typedef enum logic {
    RD_OLD = 1'b0,
    RD_NEW = 1'b1
  } rdMode_e;

  typedef struct packed {
    logic wrStb;
    logic flipPar;
    logic rdStb;
    logic outLive;
  } ctrlStrb_t;

endpackage

// File: rtl/parity_dpram_ctrl.sv
module parity_dpram_ctrl (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        injFlip,
  input  logic                        rdEn,
  output parity_dpram_pkg::ctrlStrb_t strb
);

  logic liveQ;

  // Output is forced to zero until the first accepted read.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveQ <= 1'b0;
    end else if (rdEn) begin
      liveQ <= 1'b1;
    end
  end

  always_comb begin
    strb.wrStb   = wrEn;
    strb.flipPar = wrEn & injFlip;
    strb.rdStb   = rdEn;
    strb.outLive = liveQ;
  end

endmodule

// File: rtl/parity_dpram_dp.sv
module parity_dpram_dp #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter parity_dpram_pkg::rdMode_e RD_MODE = parity_dpram_pkg::RD_OLD
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  parity_dpram_pkg::ctrlStrb_t strb,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [DATA_W-1:0]           rdData,
  output logic                        parityErr
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = DATA_W + 1;

  logic [WORD_W-1:0] memArr [DEPTH];
  logic              wrPar;

  // Even parity over the stored word, optionally inverted for injection.
  assign wrPar = (^wrData) ^ strb.flipPar;

  // Array: no reset.
  always_ff @(posedge clk) begin
    if (strb.wrStb) begin
      memArr[wrAddr] <= {wrPar, wrData};
    end
  end

  generate
    if (RD_MODE == parity_dpram_pkg::RD_NEW) begin : g_newData
      logic [ADDR_W-1:0] rdAddrQ;
      logic [WORD_W-1:0] lookWord;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          rdAddrQ <= '0;
        end else if (strb.rdStb) begin
          rdAddrQ <= rdAddr;
        end
      end

      assign lookWord  = memArr[rdAddrQ];
      assign rdData    = strb.outLive ? lookWord[DATA_W-1:0] : '0;
      assign parityErr = strb.outLive & (^lookWord);
    end else begin : g_oldData
      logic [DATA_W-1:0] dataQ;
      logic              errQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          dataQ <= '0;
          errQ  <= 1'b0;
        end else if (strb.rdStb) begin
          dataQ <= memArr[rdAddr][DATA_W-1:0];
          errQ  <= ^memArr[rdAddr];
        end
      end

      assign rdData    = strb.outLive ? dataQ : '0;
      assign parityErr = strb.outLive & errQ;
    end
  endgenerate

endmodule

// File: rtl/parity_dpram.sv
module parity_dpram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter parity_dpram_pkg::rdMode_e RD_MODE = parity_dpram_pkg::RD_OLD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              injFlip,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              parityErr
);

  parity_dpram_pkg::ctrlStrb_t strb;

  parity_dpram_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .injFlip (injFlip),
    .rdEn    (rdEn),
    .strb    (strb)
  );

  parity_dpram_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RD_MODE (RD_MODE)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .parityErr (parityErr)
  );

endmodule

// File: rtl/parity_dpram_chk.sv
module parity_dpram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter parity_dpram_pkg::rdMode_e RD_MODE = parity_dpram_pkg::RD_OLD
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              injFlip,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              parityErr
);

  logic       seenRd;
  logic [1:0] primed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenRd <= 1'b0;
      primed <= 2'd0;
    end else begin
      if (rdEn) seenRd <= 1'b1;
      if (primed != 2'd3) primed <= primed + 2'd1;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seenRd |-> (rdData == '0) && !parityErr);

  generate
    if (RD_MODE == parity_dpram_pkg::RD_NEW) begin : g_newChk
      // R7
      new_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
        rdEn && wrEn && !injFlip && (rdAddr == wrAddr)
        |=> (rdData == $past(wrData)) && !parityErr);

      // R5
      new_inject_chk: assert property (@(posedge clk) disable iff (!rstN)
        rdEn && wrEn && injFlip && (rdAddr == wrAddr) |=> parityErr);
    end else begin : g_oldChk
      // R3
      old_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !rdEn |=> $stable(rdData) && $stable(parityErr));

      // R6
      old_wr_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
        (primed == 2'd3) && $past(wrEn) && !$past(injFlip) && rdEn &&
        (rdAddr == $past(wrAddr)) && !(wrEn && (wrAddr == rdAddr))
        |=> (rdData == $past(wrData, 2)) && !parityErr);

      // R5
      old_inject_chk: assert property (@(posedge clk) disable iff (!rstN)
        (primed == 2'd3) && $past(wrEn) && $past(injFlip) && rdEn &&
        (rdAddr == $past(wrAddr)) && !(wrEn && (wrAddr == rdAddr))
        |=> parityErr);
    end
  endgenerate

endmodule

bind parity_dpram parity_dpram_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .RD_MODE (RD_MODE)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .injFlip   (injFlip),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .parityErr (parityErr)
);

// File: tb/test_parity_dpram.sv
`timescale 1ns/1ps
module test_parity_dpram;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn, injFlip, rdEn;
  logic [5:0] wrAddr, rdAddr;
  logic [7:0] wrData;
  logic [7:0] rdDataOld, rdDataNew;
  logic       errOld, errNew;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  parity_dpram #(.RD_MODE(parity_dpram_pkg::RD_OLD)) i_parity_dpram (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .injFlip(injFlip), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdDataOld), .parityErr(errOld)
  );

  parity_dpram #(.RD_MODE(parity_dpram_pkg::RD_NEW)) i_parity_dpram_new (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .injFlip(injFlip), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdDataNew), .parityErr(errNew)
  );

  typedef struct packed {
    logic       vWr;
    logic [5:0] vWa;
    logic [7:0] vWd;
    logic       vRd;
    logic [5:0] vRa;
    logic       vChk;
    logic [7:0] vExpOld;
    logic [7:0] vExpNew;
  } vec_t;

  // Table: R8 (v1), R6/R7 (v2), R6 (v3), R2 (v4, v5)
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 6'd5, 8'h3C, 1'b0, 6'd0, 1'b0, 8'h00, 8'h00},
    '{1'b1, 6'd6, 8'hA5, 1'b1, 6'd5, 1'b1, 8'h3C, 8'h3C},
    '{1'b1, 6'd5, 8'h81, 1'b1, 6'd5, 1'b1, 8'h3C, 8'h81},
    '{1'b0, 6'd0, 8'h00, 1'b1, 6'd5, 1'b1, 8'h81, 8'h81},
    '{1'b0, 6'd6, 8'hFF, 1'b1, 6'd6, 1'b1, 8'hA5, 8'hA5},
    '{1'b0, 6'd0, 8'h00, 1'b1, 6'd6, 1'b1, 8'hA5, 8'hA5}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; injFlip = 0; rdEn = 0; wrAddr = '0; rdAddr = '0; wrData = '0;
  endtask

  function automatic logic [7:0] fillVal(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    // R1 reset state, then writes without reads keep outputs at zero
    chk8("R1 old data after reset", rdDataOld, 8'h00);
    chk1("R1 old err after reset", errOld, 1'b0);
    chk8("R1 new data after reset", rdDataNew, 8'h00);
    chk1("R1 new err after reset", errNew, 1'b0);
    wrEn = 1; wrAddr = 6'd40; wrData = 8'h77; step();
    idle();
    chk8("R1 old data after write only", rdDataOld, 8'h00);
    chk8("R1 new data after write only", rdDataNew, 8'h00);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      wrEn = VECS[i].vWr; wrAddr = VECS[i].vWa; wrData = VECS[i].vWd;
      rdEn = VECS[i].vRd; rdAddr = VECS[i].vRa; injFlip = 1'b0;
      step();
      if (VECS[i].vChk) begin
        chk8($sformatf("R3 vec%0d old data", i), rdDataOld, VECS[i].vExpOld);
        chk8($sformatf("R3 vec%0d new data", i), rdDataNew, VECS[i].vExpNew);
        chk1($sformatf("R4 vec%0d old err", i), errOld, 1'b0);
        chk1($sformatf("R4 vec%0d new err", i), errNew, 1'b0);
      end
    end
    idle();

    // R9 fill all addresses, read back
    for (int a = 0; a < 64; a++) begin
      wrEn = 1; wrAddr = 6'(a); wrData = fillVal(a); step();
    end
    idle();
    for (int a = 0; a < 64; a++) begin
      rdEn = 1; rdAddr = 6'(a); step();
      chk8($sformatf("R9 old addr %0d", a), rdDataOld, fillVal(a));
      chk8($sformatf("R9 new addr %0d", a), rdDataNew, fillVal(a));
      chk1($sformatf("R4 old err addr %0d", a), errOld, 1'b0);
      chk1($sformatf("R4 new err addr %0d", a), errNew, 1'b0);
    end
    idle();

    // R2 write with wrEn low is ignored
    wrEn = 0; wrAddr = 6'd7; wrData = 8'h00; step();
    idle();
    rdEn = 1; rdAddr = 6'd7; step();
    chk8("R2 old addr 7 unchanged", rdDataOld, fillVal(7));
    chk8("R2 new addr 7 unchanged", rdDataNew, fillVal(7));
    idle();

    // R5 parity injection
    wrEn = 1; wrAddr = 6'd10; wrData = 8'h55; injFlip = 1; step();
    idle();
    rdEn = 1; rdAddr = 6'd10; step();
    chk8("R5 old data injected", rdDataOld, 8'h55);
    chk1("R5 old err injected", errOld, 1'b1);
    chk8("R5 new data injected", rdDataNew, 8'h55);
    chk1("R5 new err injected", errNew, 1'b1);
    idle();
    wrEn = 1; wrAddr = 6'd10; wrData = 8'h55; step();
    idle();
    rdEn = 1; rdAddr = 6'd10; step();
    chk1("R5 old err cleared", errOld, 1'b0);
    chk1("R5 new err cleared", errNew, 1'b0);
    idle();

    // R10 new-mode follows array; old-mode holds (R3)
    rdEn = 1; rdAddr = 6'd20; step();
    chk8("R10 old read 20", rdDataOld, fillVal(20));
    chk8("R10 new read 20", rdDataNew, fillVal(20));
    idle();
    wrEn = 1; wrAddr = 6'd20; wrData = 8'h12; step();
    idle();
    chk8("R10 new follows write", rdDataNew, 8'h12);
    chk8("R3 old holds without read", rdDataOld, fillVal(20));

    // R8 simultaneous write and read at different addresses
    wrEn = 1; wrAddr = 6'd30; wrData = 8'hC3; rdEn = 1; rdAddr = 6'd31; step();
    idle();
    chk8("R8 old read 31", rdDataOld, fillVal(31));
    chk8("R8 new read 31", rdDataNew, fillVal(31));
    rdEn = 1; rdAddr = 6'd30; step();
    idle();
    chk8("R8 old read 30", rdDataOld, 8'hC3);
    chk8("R8 new read 30", rdDataNew, 8'hC3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule